// File: doc/BRIEF.md
# Register Operation Unit with Barrel Shifter

This block is one destination register driven by a combinational operation unit. The unit takes two N-bit operands and applies the transfer, arithmetic, bitwise or shift operation chosen by a 4-bit op-code. When `load` is high, the result is written at the next rising clock edge. When `load` is low, a feedback multiplexer returns the register's own output to its input. No gate sits on the clock.

Addition, subtraction, increment, decrement and two's-complement negation all share one adder. Each of these operations chooses what feeds the adder's two inputs and its carry-in, so subtraction is the first operand plus the inverted second operand plus one.

Shifts act on operand A by a log2(N)-bit amount, using a staged barrel shifter. A separate flag flip-flop keeps the last bit that a shift pushed out of the word.

The operands and the op-code are plain control-rate inputs sampled on each edge. They carry no valid/ready handshake, so there is no back-pressure: a new operation can be committed every cycle.

Top module: `regop_unit`

## Requirements
- R1: While `rst_n` is low, the register reads 0 and the shift-out flag reads 0. The reset is asynchronous and active low.
- R2: With `load` low, both the register and the shift-out flag keep their values, whatever the op-code and operands are.
- R3: Code 1 writes A+B and code 2 writes A-B, both modulo 2^N. Subtraction is performed as A + ~B + 1.
- R4: Code 3 writes A+1 and code 4 writes A-1, both modulo 2^N.
- R5: Code 5 writes the one's complement ~A. Code 6 writes the two's complement ~A+1.
- R6: Code 0 writes A unchanged. Codes 7, 8 and 9 write the bitwise A AND B, A OR B and A XOR B.
- R7: Code 10 shifts A left by `shamt` and fills the vacated low bits with 0.
- R8: Code 11 shifts A right logically and fills the vacated high bits with 0. Code 12 shifts A right arithmetically and fills them with copies of A's MSB.
- R9: A committed shift (codes 10 to 12) with a nonzero amount s writes the last bit pushed out into the flag: A[N-s] for a left shift, A[s-1] for a right shift.
- R10: A committed shift by 0 writes A unchanged and leaves the flag unchanged.
- R11: Codes 13, 14 and 15 leave both the register and the flag unchanged, even with `load` high.
- R12: A committed operation with a code from 0 to 9 leaves the flag unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Rising-edge clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| op | input | 4 | Operation code |
| opa | input | N | Operand A; the only operand for unary ops and shifts |
| opb | input | N | Operand B |
| shamt | input | log2(N) | Shift amount |
| load | input | 1 | Commits the selected result at the next edge |
| res_q | output | N | Destination register |
| shout_q | output | 1 | Last bit shifted out |

## Verification
The hardest behaviour to reach from the ports is a flag that holds its value across operations that must not disturb it. The flag only shows a difference if it was first set to a known 1 or 0 by a shift that pushed out that particular bit. Only then can a later shift by zero, an unused code or a non-shift operation be seen to leave it alone.

The vector table therefore orders its entries to set the flag to 1 before it applies a shift by zero and then an unused code. A long random run then mixes all sixteen codes and both values of `load`, using the corner operands 0, all ones and MSB only. It compares every cycle against a running model of both the register and the flag.

// File: rtl/regop_pkg.sv
`timescale 1ns/1ps
package regop_pkg;
  typedef enum logic [3:0] {
    OP_PASS = 4'd0,
    OP_ADD  = 4'd1,
    OP_SUB  = 4'd2,
    OP_INC  = 4'd3,
    OP_DEC  = 4'd4,
    OP_NOT  = 4'd5,
    OP_NEG  = 4'd6,
    OP_AND  = 4'd7,
    OP_OR   = 4'd8,
    OP_XOR  = 4'd9,
    OP_SHL  = 4'd10,
    OP_SHR  = 4'd11,
    OP_SRA  = 4'd12
  } op_e;
endpackage

// File: rtl/regop_adder.sv
`timescale 1ns/1ps
// One shared adder; the op-code picks the operand inputs and the carry-in.
module regop_adder import regop_pkg::*; #(
  parameter int N = 8
) (
  input  logic [3:0]   op,
  input  logic [N-1:0] a,
  input  logic [N-1:0] b,
  output logic [N-1:0] sum
);
  logic [N-1:0] x, y;
  logic         cin;

  always_comb begin
    x   = a;
    y   = '0;
    cin = 1'b0;
    case (op)
      OP_ADD: y = b;
      OP_SUB: begin y = ~b; cin = 1'b1; end
      OP_INC: cin = 1'b1;
      OP_DEC: y = '1;
      OP_NEG: begin x = ~a; cin = 1'b1; end
      default: ;
    endcase
  end

  assign sum = x + y + {{(N-1){1'b0}}, cin};
endmodule

// File: rtl/regop_bitwise.sv
`timescale 1ns/1ps
module regop_bitwise import regop_pkg::*; #(
  parameter int N = 8
) (
  input  logic [3:0]   op,
  input  logic [N-1:0] a,
  input  logic [N-1:0] b,
  output logic [N-1:0] res
);
  always_comb begin
    case (op)
      OP_NOT:  res = ~a;
      OP_AND:  res = a & b;
      OP_OR:   res = a | b;
      OP_XOR:  res = a ^ b;
      default: res = a;
    endcase
  end
endmodule

// File: rtl/regop_shifter.sv
`timescale 1ns/1ps
// Staged barrel shifter on an (N+1)-bit word. The extra bit collects the
// last bit dropped off the end of the word.
module regop_shifter #(
  parameter int N  = 8,
  parameter int SW = 3
) (
  input  logic [N-1:0]  a,
  input  logic [SW-1:0] amt,
  input  logic          arith,
  output logic [N-1:0]  left_res,
  output logic          left_out,
  output logic [N-1:0]  right_res,
  output logic          right_out
);
  logic [N:0] lv [SW+1];
  logic [N:0] rv [SW+1];
  logic       fill;

  assign fill  = arith & a[N-1];
  assign lv[0] = {1'b0, a};
  assign rv[0] = {a, 1'b0};

  for (genvar k = 0; k < SW; k++) begin : g_stage
    localparam int SH = 1 << k;
    assign lv[k+1] = amt[k] ? {lv[k][N-SH:0], {SH{1'b0}}} : lv[k];
    assign rv[k+1] = amt[k] ? {{SH{fill}}, rv[k][N:SH]}   : rv[k];
  end

  assign left_res  = lv[SW][N-1:0];
  assign left_out  = lv[SW][N];
  assign right_res = rv[SW][N:1];
  assign right_out = rv[SW][0];
endmodule

// File: rtl/regop_unit.sv
`timescale 1ns/1ps
module regop_unit import regop_pkg::*; #(
  parameter int N = 8,
  localparam int SW = (N > 2) ? $clog2(N) : 1
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic [3:0]    op,
  input  logic [N-1:0]  opa,
  input  logic [N-1:0]  opb,
  input  logic [SW-1:0] shamt,
  input  logic          load,
  output logic [N-1:0]  res_q,
  output logic          shout_q
);
  logic [N-1:0] sum, bw, shl_res, shr_res;
  logic         shl_out, shr_out;
  logic [N-1:0] res_d;
  logic         shout_d;
  logic         amt_nz;

  regop_adder #(.N(N)) u_add (.op(op), .a(opa), .b(opb), .sum(sum));

  regop_bitwise #(.N(N)) u_bw (.op(op), .a(opa), .b(opb), .res(bw));

  regop_shifter #(.N(N), .SW(SW)) u_sh (
    .a(opa), .amt(shamt), .arith(op == OP_SRA),
    .left_res(shl_res), .left_out(shl_out),
    .right_res(shr_res), .right_out(shr_out)
  );

  assign amt_nz = |shamt;

  // Feedback multiplexer: the default keeps the current contents.
  always_comb begin
    res_d   = res_q;
    shout_d = shout_q;
    if (load) begin
      case (op)
        OP_PASS: res_d = opa;
        OP_ADD, OP_SUB, OP_INC, OP_DEC, OP_NEG: res_d = sum;
        OP_NOT, OP_AND, OP_OR, OP_XOR:          res_d = bw;
        OP_SHL: begin
          res_d = shl_res;
          if (amt_nz) shout_d = shl_out;
        end
        OP_SHR, OP_SRA: begin
          res_d = shr_res;
          if (amt_nz) shout_d = shr_out;
        end
        default: ;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      res_q   <= '0;
      shout_q <= 1'b0;
    end else begin
      res_q   <= res_d;
      shout_q <= shout_d;
    end
  end
endmodule

// File: rtl/regop_unit_chk.sv
`timescale 1ns/1ps
module regop_unit_chk #(
  parameter int N  = 8,
  parameter int SW = 3
) (
  input logic          clk,
  input logic          rst_n,
  input logic [3:0]    op,
  input logic [N-1:0]  opa,
  input logic [N-1:0]  opb,
  input logic [SW-1:0] shamt,
  input logic          load,
  input logic [N-1:0]  res_q,
  input logic          shout_q
);
  p_reset_zero_r1: assert property (@(posedge clk)
    !rst_n |-> (res_q == '0 && !shout_q));

  p_hold_r2: assert property (@(posedge clk) disable iff (!rst_n)
    !load |=> ($stable(res_q) && $stable(shout_q)));

  p_add_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (load && op == 4'd1) |=> res_q == N'($past(opa) + $past(opb)));

  p_sra_sign_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (load && op == 4'd12) |=> res_q[N-1] == $past(opa[N-1]));

  p_zero_shift_r10: assert property (@(posedge clk) disable iff (!rst_n)
    (load && op >= 4'd10 && op <= 4'd12 && shamt == '0)
      |=> ($stable(shout_q) && res_q == $past(opa)));

  p_unused_code_r11: assert property (@(posedge clk) disable iff (!rst_n)
    (load && op >= 4'd13) |=> ($stable(res_q) && $stable(shout_q)));

  p_flag_keep_r12: assert property (@(posedge clk) disable iff (!rst_n)
    (load && op <= 4'd9) |=> $stable(shout_q));
endmodule

bind regop_unit regop_unit_chk #(.N(N), .SW(SW)) u_chk (
  .clk(clk), .rst_n(rst_n), .op(op), .opa(opa), .opb(opb),
  .shamt(shamt), .load(load), .res_q(res_q), .shout_q(shout_q)
);

// File: tb/regop_unit_test.sv
`timescale 1ns/1ps
module regop_unit_test;
  logic       clk = 1'b0;
  logic       rst_n = 1'b1;
  logic [3:0] op = '0;
  logic [7:0] opa = '0, opb = '0;
  logic [2:0] shamt = '0;
  logic       load = 1'b0;
  logic [7:0] res_q;
  logic       shout_q;

  int nvec = 0;
  int nbad = 0;

  regop_unit #(.N(8)) uut (
    .clk(clk), .rst_n(rst_n), .op(op), .opa(opa), .opb(opb),
    .shamt(shamt), .load(load), .res_q(res_q), .shout_q(shout_q)
  );

  always #2.5 clk = ~clk;

  // Fields: op, A, B, shift amount, expected register, expected flag.
  localparam int NV = 20;
  localparam logic [31:0] VEC [NV] = '{
    {4'd0,  8'h3C, 8'h00, 3'd0, 8'h3C, 1'b0},  // R6 transfer
    {4'd1,  8'hF0, 8'h20, 3'd0, 8'h10, 1'b0},  // R3 add wraps
    {4'd2,  8'h05, 8'h07, 3'd0, 8'hFE, 1'b0},  // R3 sub borrows
    {4'd3,  8'hFF, 8'h00, 3'd0, 8'h00, 1'b0},  // R4 inc wraps
    {4'd4,  8'h00, 8'h00, 3'd0, 8'hFF, 1'b0},  // R4 dec wraps
    {4'd5,  8'hA5, 8'h00, 3'd0, 8'h5A, 1'b0},  // R5 one's complement
    {4'd6,  8'h01, 8'h00, 3'd0, 8'hFF, 1'b0},  // R5 negate
    {4'd6,  8'h80, 8'h00, 3'd0, 8'h80, 1'b0},  // R5 negate MSB only
    {4'd7,  8'hCC, 8'hAA, 3'd0, 8'h88, 1'b0},  // R6 and
    {4'd8,  8'hCC, 8'hAA, 3'd0, 8'hEE, 1'b0},  // R6 or
    {4'd9,  8'hCC, 8'hAA, 3'd0, 8'h66, 1'b0},  // R6 xor
    {4'd10, 8'h81, 8'h00, 3'd1, 8'h02, 1'b1},  // R7 R9
    {4'd11, 8'h81, 8'h00, 3'd1, 8'h40, 1'b1},  // R8 R9
    {4'd10, 8'h0F, 8'h00, 3'd4, 8'hF0, 1'b0},  // R7 R9
    {4'd12, 8'h84, 8'h00, 3'd2, 8'hE1, 1'b0},  // R8 R9
    {4'd12, 8'h97, 8'h00, 3'd3, 8'hF2, 1'b1},  // R8 R9
    {4'd11, 8'h97, 8'h00, 3'd0, 8'h97, 1'b1},  // R10 flag kept
    {4'd13, 8'h11, 8'h22, 3'd5, 8'h97, 1'b1},  // R11 unused code
    {4'd11, 8'h80, 8'h00, 3'd7, 8'h01, 1'b0},  // R8 R9 full shift
    {4'd2,  8'h00, 8'h01, 3'd0, 8'hFF, 1'b0}   // R3 R12
  };

  function automatic string tag_of(input logic [3:0] o, input logic ld);
    if (!ld) return "R2";
    case (o)
      4'd1, 4'd2: return "R3";
      4'd3, 4'd4: return "R4";
      4'd5, 4'd6: return "R5";
      4'd0, 4'd7, 4'd8, 4'd9: return "R6";
      4'd10: return "R7";
      4'd11, 4'd12: return "R8";
      default: return "R11";
    endcase
  endfunction

  task automatic check(input string tag, input logic [7:0] act_q, input logic act_f,
                       input logic [7:0] exp_q, input logic exp_f);
    nvec++;
    if (act_q !== exp_q || act_f !== exp_f) begin
      nbad++;
      $display("FAIL %s: reg=%h flag=%b expected reg=%h flag=%b",
               tag, act_q, act_f, exp_q, exp_f);
    end
  endtask

  // Called at a negative edge; drives the inputs and returns after the next negative edge.
  task automatic step(input logic [3:0] o, input logic [7:0] a, input logic [7:0] b,
                      input logic [2:0] s, input logic ld);
    op = o; opa = a; opb = b; shamt = s; load = ld;
    @(negedge clk);
  endtask

  function automatic void model(input logic [3:0] o, input logic [7:0] a, input logic [7:0] b,
                                input logic [2:0] s, input logic ld,
                                inout logic [7:0] q, inout logic f);
    if (!ld) return;
    case (o)
      4'd0:  q = a;
      4'd1:  q = a + b;
      4'd2:  q = a - b;
      4'd3:  q = a + 8'd1;
      4'd4:  q = a - 8'd1;
      4'd5:  q = ~a;
      4'd6:  q = 8'd0 - a;
      4'd7:  q = a & b;
      4'd8:  q = a | b;
      4'd9:  q = a ^ b;
      4'd10: begin q = a << s; if (s != 0) f = a[8 - s]; end
      4'd11: begin q = a >> s; if (s != 0) f = a[s - 1]; end
      4'd12: begin q = 8'($signed(a) >>> s); if (s != 0) f = a[s - 1]; end
      default: ;
    endcase
  endfunction

  function automatic logic [7:0] pick();
    case ($urandom_range(0, 4))
      0: return 8'h00;
      1: return 8'hFF;
      2: return 8'h80;
      default: return 8'($urandom);
    endcase
  endfunction

  initial begin
    #(200000 * 5);
    nbad++;
    $display("FAIL watchdog: state=running expected=finished");
    $display("== %0d vectors applied, %0d miscompares ==", nvec, nbad);
    $finish;
  end

  initial begin
    logic [7:0] mq;
    logic       mf;
    #1 rst_n = 1'b0;
    repeat (3) @(negedge clk);
    check("R1 reset", res_q, shout_q, 8'h00, 1'b0);
    rst_n = 1'b1;
    @(negedge clk);

    for (int i = 0; i < NV; i++) begin
      logic [31:0] v;
      v = VEC[i];
      step(v[31:28], v[27:20], v[19:12], v[11:9], 1'b1);
      check(tag_of(v[31:28], 1'b1), res_q, shout_q, v[8:1], v[0]);
    end

    // Set the flag to 1, then show that load low and non-shift codes keep it.
    step(4'd10, 8'h80, 8'h00, 3'd1, 1'b1);
    check("R9 left out MSB", res_q, shout_q, 8'h00, 1'b1);
    step(4'd1, 8'h12, 8'h34, 3'd3, 1'b0);
    check("R2 hold on add", res_q, shout_q, 8'h00, 1'b1);
    step(4'd11, 8'hFF, 8'h00, 3'd4, 1'b0);
    check("R2 hold on shift", res_q, shout_q, 8'h00, 1'b1);
    step(4'd9, 8'h0F, 8'hFF, 3'd2, 1'b1);
    check("R12 xor keeps flag", res_q, shout_q, 8'hF0, 1'b1);
    step(4'd15, 8'h00, 8'h00, 3'd1, 1'b1);
    check("R11 code 15", res_q, shout_q, 8'hF0, 1'b1);
    step(4'd10, 8'hFF, 8'h00, 3'd0, 1'b1);
    check("R10 zero left shift", res_q, shout_q, 8'hFF, 1'b1);

    mq = res_q;
    mf = 1'b1;
    for (int i = 0; i < 400; i++) begin
      logic [3:0] o;
      logic [7:0] a, b;
      logic [2:0] s;
      logic       ld;
      o  = 4'($urandom_range(0, 15));
      a  = pick();
      b  = pick();
      s  = 3'($urandom);
      ld = ($urandom_range(0, 3) != 0);
      step(o, a, b, s, ld);
      model(o, a, b, s, ld, mq, mf);
      check((o >= 4'd10 && o <= 4'd12) ? "R9" :
            ((ld && o <= 4'd9) ? "R12" : tag_of(o, ld)),
            res_q, shout_q, mq, mf);
    end

    rst_n = 1'b0;
    @(negedge clk);
    check("R1 reset mid-run", res_q, shout_q, 8'h00, 1'b0);
    rst_n = 1'b1;
    @(negedge clk);

    $display("== %0d vectors applied, %0d miscompares ==", nvec, nbad);
    $finish;
  end
endmodule